// File: doc/BRIEF.md
# XOR-Coded Three-Port Memory

This block is a true three-port RAM. Each of its three ports may issue either a read or a write in any cycle, using one address for both directions. Storage is a 3x3 grid of simple dual-port banks. Each bank has one read port and one write port.

Bank (r,c) takes writes only from port r and serves reads only to port c. The value of a word is never held in any one bank. It is the XOR of the three banks in any column at that address, and every column gives the same value.

A read on port p returns the XOR of its column. A write on port p first reads the two other-row banks of its column. It then XORs them with the new data and stores the result across its whole row. This keeps every column's XOR equal to the new word.

Bank reads take one cycle, so a write is split into two stages: the column read, then the row store one cycle later. Each bank forwards a row store that lands in the same cycle as a read of the same address. As a result, every request sees all writes issued in earlier cycles.

Top module: `xmp_ram`

## Requirements
- R1: Following reset, every `rsp_valid` bit is 0 and every `rsp_rdata` lane is 0.
- R2: A read request (`req_valid`=1, `req_write`=0) on port p raises `rsp_valid[p]` exactly one cycle later, with the data on `rsp_rdata[p]`. An idle port gives no response.
- R3: Every word reads as zero until it is first written.
- R4: A write on any port is returned by a later read of that address on any port, including other ports.
- R5: A request issued in the cycle right after a write to the same address sees the new value. This holds for a read, and for another write whose encoding depends on the earlier one.
- R6: A read issued in the same cycle as another port's write to the same address returns the value from before that write.
- R7: All three ports may write different addresses in one cycle, and all three words are kept.
- R8: A write request (`req_write`=1) produces no response on its port.
- R9: Cycles with no requests leave the stored contents unchanged.
- R10: At most one port may write a given address in a given cycle. Collisions are illegal, and the stored result of a collision is undefined.
- R11: Reads of the same address on several ports in one cycle all return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 3 | Per-port request strobe |
| req_write | input | 3 | Per-port direction: 1 = write, 0 = read |
| req_addr | input | 3 x ADDR_W | Per-port word address, shared by the read and write paths |
| req_wdata | input | 3 x DATA_W | Per-port write data |
| rsp_valid | output | 3 | Per-port read-data strobe, one cycle after the read request |
| rsp_rdata | output | 3 x DATA_W | Per-port read data (XOR of the port's column) |

## Verification
Two things can meet on the same address in one cycle. One port's row store (the second stage of its write) can coincide with another port's column read, whether that read belongs to a memory read or to the first stage of a new write. The bench provokes this directly with back-to-back writes to one address from all three ports in turn, and with a write followed at once by a read from another port. Random traffic over a 16-word window also makes such meetings frequent. Each read result is compared with a plain single-array model that applies writes only after the reads of the same cycle. A second case, a read on one port in the very cycle another port writes that address, is judged against the value from before the write.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e op_decode(input logic valid, input logic write);
        if (!valid) begin
            return OP_IDLE;
        end
        return write ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/xmp_bank.sv
module xmp_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read register; a row store landing on the same address in this
    // cycle is forwarded so the reader never sees the stale word.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            if (wr_en && (wr_addr == rd_addr)) begin
                rd_q <= wr_data;
            end else begin
                rd_q <= mem[rd_addr];
            end
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/xmp_port_ctrl.sv
module xmp_port_ctrl
    import xmp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int PORT_ID = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [NPORT-1:0][DATA_W-1:0] col_data,
    output logic                         row_wr_en,
    output logic [ADDR_W-1:0]            row_wr_addr,
    output logic [DATA_W-1:0]            row_wr_data,
    output logic                         rsp_valid,
    output logic [DATA_W-1:0]            rsp_rdata
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] col_full;
    logic [DATA_W-1:0] col_others;

    // Second stage: the request as it was when its column was read.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            op_q    <= op_decode(req_valid, req_write);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Decode: whole column; encode: column without this port's own row.
    always_comb begin
        col_full   = '0;
        col_others = '0;
        for (int r = 0; r < NPORT; r++) begin
            col_full = col_full ^ col_data[r];
            if (r != PORT_ID) begin
                col_others = col_others ^ col_data[r];
            end
        end
    end

    assign row_wr_en   = (op_q == OP_WRITE);
    assign row_wr_addr = addr_q;
    assign row_wr_data = wdata_q ^ col_others;
    assign rsp_valid   = (op_q == OP_READ);
    assign rsp_rdata   = col_full;

endmodule

// File: rtl/xmp_ram.sv
module xmp_ram
    import xmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             req_valid,
    input  logic [NPORT-1:0]             req_write,
    input  logic [NPORT-1:0][ADDR_W-1:0] req_addr,
    input  logic [NPORT-1:0][DATA_W-1:0] req_wdata,
    output logic [NPORT-1:0]             rsp_valid,
    output logic [NPORT-1:0][DATA_W-1:0] rsp_rdata
);

    // cell_q[c][r] is the read output of bank (row r, column c).
    logic [NPORT-1:0][NPORT-1:0][DATA_W-1:0] cell_q;
    logic [NPORT-1:0]                        row_en;
    logic [NPORT-1:0][ADDR_W-1:0]            row_addr;
    logic [NPORT-1:0][DATA_W-1:0]            row_data;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xmp_port_ctrl #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .PORT_ID(p)
        ) u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .req_valid  (req_valid[p]),
            .req_write  (req_write[p]),
            .req_addr   (req_addr[p]),
            .req_wdata  (req_wdata[p]),
            .col_data   (cell_q[p]),
            .row_wr_en  (row_en[p]),
            .row_wr_addr(row_addr[p]),
            .row_wr_data(row_data[p]),
            .rsp_valid  (rsp_valid[p]),
            .rsp_rdata  (rsp_rdata[p])
        );
    end

    for (genvar r = 0; r < NPORT; r++) begin : g_row
        for (genvar c = 0; c < NPORT; c++) begin : g_col
            xmp_bank #(
                .DATA_W(DATA_W),
                .DEPTH (DEPTH)
            ) u_bank (
                .clk    (clk),
                .rst    (rst),
                .rd_en  (req_valid[c]),
                .rd_addr(req_addr[c]),
                .wr_en  (row_en[r]),
                .wr_addr(row_addr[r]),
                .wr_data(row_data[r]),
                .rd_data(cell_q[c][r])
            );
        end
    end

endmodule

// File: rtl/xmp_checker.sv
module xmp_checker
    import xmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NPORT-1:0]             req_valid,
    input logic [NPORT-1:0]             req_write,
    input logic [NPORT-1:0][ADDR_W-1:0] req_addr,
    input logic [NPORT-1:0]             rsp_valid,
    input logic [NPORT-1:0][DATA_W-1:0] rsp_rdata
);

    for (genvar p = 0; p < NPORT; p++) begin : g_one
        // R2: a response follows a read request by exactly one cycle
        p_read_resp_r2: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (rsp_valid[p] == $past(req_valid[p] && !req_write[p])));

        // R8: a write is never answered
        p_write_silent_r8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(req_valid[p] && req_write[p])) |-> !rsp_valid[p]);
    end

    for (genvar a = 0; a < NPORT; a++) begin : g_pa
        for (genvar b = a + 1; b < NPORT; b++) begin : g_pb
            // R10: no two ports store to one address in one cycle
            p_no_collision_r10: assert property (@(posedge clk) disable iff (rst)
                !(req_valid[a] && req_write[a] && req_valid[b] && req_write[b]
                  && (req_addr[a] == req_addr[b])));

            // R11: same-address reads in one cycle agree across columns
            p_same_addr_agree_r11: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(req_valid[a] && !req_write[a] && req_valid[b]
                  && !req_write[b] && (req_addr[a] == req_addr[b])))
                |-> (rsp_rdata[a] == rsp_rdata[b]));
        end
    end

endmodule

bind xmp_ram xmp_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
);

// File: tb/xmp_ram_test.sv
module xmp_ram_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NVEC = 12;

    // Vector: {port[1:0], write, addr[7:0], data[31:0]}; for reads data is the expected word.
    localparam logic [42:0] TBL [NVEC] = '{
        {2'd0, 1'b1, 8'h05, 32'hA5A5_0001},
        {2'd1, 1'b0, 8'h05, 32'hA5A5_0001},
        {2'd2, 1'b0, 8'h05, 32'hA5A5_0001},
        {2'd2, 1'b1, 8'h05, 32'h0000_FFFF},
        {2'd0, 1'b0, 8'h05, 32'h0000_FFFF},
        {2'd1, 1'b1, 8'h10, 32'hDEAD_BEEF},
        {2'd2, 1'b0, 8'h10, 32'hDEAD_BEEF},
        {2'd0, 1'b0, 8'h11, 32'h0000_0000},
        {2'd1, 1'b1, 8'hFF, 32'h1234_5678},
        {2'd0, 1'b0, 8'hFF, 32'h1234_5678},
        {2'd2, 1'b1, 8'h00, 32'hCAFE_F00D},
        {2'd1, 1'b0, 8'h00, 32'hCAFE_F00D}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NP-1:0]        in_v = '0;
    logic [NP-1:0]        in_w = '0;
    logic [NP-1:0][AW-1:0] in_a = '0;
    logic [NP-1:0][DW-1:0] in_d = '0;
    logic [NP-1:0]        rsp_valid;
    logic [NP-1:0][DW-1:0] rsp_rdata;

    logic [DW-1:0] ref_mem [1 << AW];
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xmp_ram #(.DATA_W(DW), .DEPTH(1 << AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(in_v),
        .req_write(in_w),
        .req_addr (in_a),
        .req_wdata(in_d),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        in_v[p] = 1'b1;
        in_w[p] = w;
        in_a[p] = a;
        in_d[p] = d;
    endtask

    // Run one cycle: expectations from the model, writes applied after reads,
    // results sampled at the following falling edge.
    task automatic commit(input string tag);
        logic [NP-1:0]        pv;
        logic [NP-1:0][DW-1:0] pd;
        for (int p = 0; p < NP; p++) begin
            pv[p] = in_v[p] && !in_w[p];
            pd[p] = ref_mem[in_a[p]];
        end
        for (int p = 0; p < NP; p++) begin
            if (in_v[p] && in_w[p]) ref_mem[in_a[p]] = in_d[p];
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(rsp_valid[p] == pv[p], pv[p] ? "R2" : "R8", $sformatf("valid port %0d", p),
                DW'(rsp_valid[p]), DW'(pv[p]));
            if (pv[p]) begin
                chk(rsp_rdata[p] == pd[p], tag, $sformatf("data port %0d", p),
                    rsp_rdata[p], pd[p]);
            end
        end
        in_v = '0;
        in_w = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            chk(rsp_valid[p] == 1'b0, "R1", "valid after reset", DW'(rsp_valid[p]), '0);
            chk(rsp_rdata[p] == '0, "R1", "rdata after reset", rsp_rdata[p], '0);
        end

        // R3: unwritten words on every port
        drive(0, 0, 8'h40, '0); drive(1, 0, 8'h41, '0); drive(2, 0, 8'hFE, '0);
        commit("R3");

        // Vector table walk (R4, R5 back-to-back, R3 unwritten)
        for (int i = 0; i < NVEC; i++) begin
            int p;
            p = int'(TBL[i][42:41]);
            drive(p, TBL[i][40], TBL[i][39:32], TBL[i][31:0]);
            commit("R4");
            if (!TBL[i][40]) begin
                chk(rsp_rdata[p] == TBL[i][31:0], "R4", $sformatf("vector %0d", i),
                    rsp_rdata[p], TBL[i][31:0]);
            end
        end

        // R6: read in the same cycle as another port's write sees the old word
        drive(0, 1, 8'h20, 32'h600D_0006); drive(1, 0, 8'h20, '0);
        commit("R6");
        chk(rsp_rdata[1] == '0, "R6", "same-cycle read", rsp_rdata[1], '0);
        drive(2, 0, 8'h20, '0);
        commit("R5");
        chk(rsp_rdata[2] == 32'h600D_0006, "R5", "next-cycle read", rsp_rdata[2], 32'h600D_0006);

        // R5: write chain on one address from all ports, cycle after cycle
        drive(0, 1, 8'h30, 32'h1111_1111); commit("R5");
        drive(1, 1, 8'h30, 32'h2222_2222); commit("R5");
        drive(2, 1, 8'h30, 32'h3333_3333); commit("R5");
        drive(0, 0, 8'h30, '0); commit("R5");
        chk(rsp_rdata[0] == 32'h3333_3333, "R5", "write chain", rsp_rdata[0], 32'h3333_3333);

        // R7: three writes in one cycle, read back on rotated ports
        drive(0, 1, 8'h50, 32'hAAAA_0000);
        drive(1, 1, 8'h51, 32'hBBBB_1111);
        drive(2, 1, 8'h52, 32'hCCCC_2222);
        commit("R7");
        drive(0, 0, 8'h52, '0); drive(1, 0, 8'h50, '0); drive(2, 0, 8'h51, '0);
        commit("R7");
        chk(rsp_rdata[1] == 32'hAAAA_0000, "R7", "port0 word", rsp_rdata[1], 32'hAAAA_0000);
        chk(rsp_rdata[2] == 32'hBBBB_1111, "R7", "port1 word", rsp_rdata[2], 32'hBBBB_1111);
        chk(rsp_rdata[0] == 32'hCCCC_2222, "R7", "port2 word", rsp_rdata[0], 32'hCCCC_2222);

        // R9 + R11: idle cycles, then one address on all ports
        repeat (5) commit("R9");
        drive(0, 0, 8'h30, '0); drive(1, 0, 8'h30, '0); drive(2, 0, 8'h30, '0);
        commit("R9");
        for (int p = 0; p < NP; p++) begin
            chk(rsp_rdata[p] == 32'h3333_3333, "R11", $sformatf("agree port %0d", p),
                rsp_rdata[p], 32'h3333_3333);
        end

        // Random mixed traffic over a small window; no same-address write pairs (R10)
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 3) != 0) begin
                    drive(p, 1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)), $urandom);
                end
            end
            for (int p = 1; p < NP; p++) begin
                for (int q = 0; q < p; q++) begin
                    if (in_v[p] && in_w[p] && in_v[q] && in_w[q] && in_a[p] == in_a[q])
                        in_w[p] = 1'b0;
                end
            end
            commit("R4");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule